// File: doc/BRIEF.md
# Bit-Replicating Transmit Oversampler Gearbox

This block lets a serial transmitter that runs at one fixed line rate carry data at a fraction of that rate. It takes line-coded symbols (10 bits each by default, already DC-balanced by an upstream encoder) and repeats every symbol bit a fixed number of times. The widened frame is then cut into narrower words that feed the transmitter's parallel input. With the defaults, each symbol becomes 100 bits. These go out as five 20-bit words, one per parallel clock. A 1250 Mbps serializer therefore carries 125 Mbps of payload, and the parallel clock runs at 62.5 MHz.

Symbols arrive on a valid/ready handshake. The block can take a new symbol only at a frame boundary, so one symbol is accepted every five cycles. When no symbol is offered at a boundary, the block sends a full frame built from a replicated idle symbol, which is a comma character by default. The serializer is assumed to send the least significant bit of each parallel word first. The parameters must satisfy `NUM_SLICES * OUT_W == SYM_W * REP`; any other combination stops elaboration.

Top module: `bitRepTxGearbox`

## Requirements
- R1: Each symbol bit `symData[i]` occupies expanded bits `i*REP` to `i*REP+REP-1`, so bit order is kept. For example, a symbol whose low bits are 1,0,1 (bit 0 = 1) produces `20'h003FF` as its first word.
- R2: The expanded frame goes out as NUM_SLICES consecutive words, one per clock. Word k carries expanded bits `k*OUT_W` to `k*OUT_W+OUT_W-1`, so `symData[0]` fills `txWord[REP-1:0]` of the first word.
- R3: `symReady` is high in exactly one cycle out of every NUM_SLICES. That cycle is the one presenting the last word of the current frame.
- R4: A symbol is accepted at a rising edge where both `symValid` and `symReady` are high. Its first word appears on `txWord` in the following cycle.
- R5: If `symValid` is low when `symReady` is high, the next frame is the replicated idle symbol `IDLE_SYM`. The default is `10'b0101111100`, with bit 0 sent first.
- R6: `symData` and `symValid` have no effect on `txWord` unless `symReady` is high.
- R7: A synchronous reset (`rst` high) sets the frame position to word 0 and loads the idle symbol. `txWord` then shows word 0 of the idle frame and `symReady` is low.
- R8: When `symValid` stays high, symbols are taken back to back with no idle word between frames. Any NUM_SLICES*8 consecutive cycles accept exactly 8 symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmitter parallel (core) clock |
| rst | input | 1 | Synchronous reset, active high |
| symValid | input | 1 | A coded symbol is offered |
| symReady | output | 1 | The block accepts a symbol at this edge |
| symData | input | SYM_W | Coded symbol, bit 0 sent first |
| txWord | output | OUT_W | Parallel word to the serializer, LSB sent first |

## Verification
The bench builds the block with its defaults: 10-bit symbols, tenfold replication and five 20-bit words. Each word therefore holds exactly two symbol bits. A mistake in the bit-to-word mapping or in the order of the five slices changes a word the model predicts. The five-cycle frame is short, so a few hundred cycles cover every slice position many times. Those cycles include accepts, idle fills, data changes between boundaries and a reset in the middle of a frame.

// File: rtl/bitRepGbxPkg.sv
package bitRepGbxPkg;

  // Frame-boundary strobes from control to datapath
  typedef struct packed {
    logic frameEnd;  // last word of the current frame is on the output
    logic takeSym;   // load the offered symbol for the next frame
    logic takeIdle;  // load the idle symbol for the next frame
  } gbxStrobes_t;

endpackage

// File: rtl/gbxCtrl.sv
module gbxCtrl
  import bitRepGbxPkg::*;
#(
  parameter int NUM_SLICES = 5,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             symValid,
  output logic             symReady,
  output logic [CNT_W-1:0] sliceCnt,
  output gbxStrobes_t      strobes
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_SLICES - 1);

  logic lastSlice;
  assign lastSlice = (sliceCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)            sliceCnt <= '0;
    else if (lastSlice) sliceCnt <= '0;
    else                sliceCnt <= sliceCnt + 1'b1;
  end

  assign symReady         = lastSlice;
  assign strobes.frameEnd = lastSlice;
  assign strobes.takeSym  = lastSlice & symValid;
  assign strobes.takeIdle = lastSlice & ~symValid;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    sliceCnt <= LAST); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (sliceCnt != LAST) |=> (sliceCnt == $past(sliceCnt) + 1'b1)); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (sliceCnt == LAST) |=> (sliceCnt == '0)); // R8

  generate
    if (NUM_SLICES > 1) begin : g_spacing
      AST_READY_SPACING: assert property (@(posedge clk) disable iff (rst)
        symReady |=> !symReady); // R3
    end
  endgenerate

endmodule

// File: rtl/gbxDatapath.sv
module gbxDatapath
  import bitRepGbxPkg::*;
#(
  parameter int               SYM_W    = 10,
  parameter int               REP      = 10,
  parameter int               OUT_W    = 20,
  parameter int               CNT_W    = 3,
  parameter logic [SYM_W-1:0] IDLE_SYM = 10'b0101111100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] symData,
  input  gbxStrobes_t      strobes,
  input  logic [CNT_W-1:0] sliceCnt,
  output logic [OUT_W-1:0] txWord
);

  localparam int EXP_W = SYM_W * REP;

  logic [SYM_W-1:0] curSym;
  logic [EXP_W-1:0] expanded;

  always_ff @(posedge clk) begin
    if (rst)                   curSym <= IDLE_SYM;
    else if (strobes.takeSym)  curSym <= symData;
    else if (strobes.takeIdle) curSym <= IDLE_SYM;
  end

  // Every symbol bit fans out to REP adjacent frame bits
  generate
    for (genvar b = 0; b < SYM_W; b++) begin : g_bit
      for (genvar r = 0; r < REP; r++) begin : g_rep
        assign expanded[b*REP + r] = curSym[b];
      end
    end
  endgenerate

  assign txWord = expanded[int'(sliceCnt)*OUT_W +: OUT_W];

  AST_HOLD_SYM: assert property (@(posedge clk) disable iff (rst)
    !strobes.frameEnd |=> $stable(curSym)); // R6
  AST_LOAD_SYM: assert property (@(posedge clk) disable iff (rst)
    strobes.takeSym |=> (curSym == $past(symData))); // R4
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    strobes.takeIdle |=> (curSym == IDLE_SYM)); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (curSym == IDLE_SYM)); // R7

endmodule

// File: rtl/bitRepTxGearbox.sv
module bitRepTxGearbox
  import bitRepGbxPkg::*;
#(
  parameter int               SYM_W      = 10,
  parameter int               REP        = 10,
  parameter int               OUT_W      = 20,
  parameter int               NUM_SLICES = 5,
  parameter logic [SYM_W-1:0] IDLE_SYM   = 10'b0101111100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             symValid,
  output logic             symReady,
  input  logic [SYM_W-1:0] symData,
  output logic [OUT_W-1:0] txWord
);

  localparam int CNT_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

  generate
    if (NUM_SLICES * OUT_W != SYM_W * REP) begin : g_badParams
      $error("bitRepTxGearbox: NUM_SLICES*OUT_W must equal SYM_W*REP");
    end
  endgenerate

  gbxStrobes_t      strobes;
  logic [CNT_W-1:0] sliceCnt;

  gbxCtrl #(
    .NUM_SLICES(NUM_SLICES),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .symValid (symValid),
    .symReady (symReady),
    .sliceCnt (sliceCnt),
    .strobes  (strobes)
  );

  gbxDatapath #(
    .SYM_W   (SYM_W),
    .REP     (REP),
    .OUT_W   (OUT_W),
    .CNT_W   (CNT_W),
    .IDLE_SYM(IDLE_SYM)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .symData  (symData),
    .strobes  (strobes),
    .sliceCnt (sliceCnt),
    .txWord   (txWord)
  );

endmodule

// File: tb/bitRepTxGearbox_tb_top.sv
module bitRepTxGearbox_tb_top;

  localparam int         SYM_W = 10;
  localparam int         REP   = 10;
  localparam int         OUT_W = 20;
  localparam int         NSL   = 5;
  localparam logic [9:0] IDLE  = 10'b0101111100;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             symValid = 1'b0;
  logic [SYM_W-1:0] symData = '0;
  logic             symReady;
  logic [OUT_W-1:0] txWord;

  always #2 clk = ~clk;

  bitRepTxGearbox #(
    .SYM_W(SYM_W), .REP(REP), .OUT_W(OUT_W), .NUM_SLICES(NSL), .IDLE_SYM(IDLE)
  ) dut_i (
    .clk(clk), .rst(rst), .symValid(symValid), .symReady(symReady),
    .symData(symData), .txWord(txWord)
  );

  int    checks = 0;
  int    errors = 0;
  int    phase  = 0;
  int    accepts = 0;
  bit    finished = 0;
  string tag = "R7";
  bit    expQ[$];
  logic [OUT_W-1:0] obsWord;

  function automatic void pushSym(logic [SYM_W-1:0] s);
    for (int i = 0; i < SYM_W; i++)
      for (int r = 0; r < REP; r++) expQ.push_back(s[i]);
  endfunction

  function automatic void check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // Compare this cycle's outputs, then drive inputs for the coming edge
  task automatic stepBody(logic v, logic [SYM_W-1:0] d);
    logic [OUT_W-1:0] expW;
    bit expR;
    for (int j = 0; j < OUT_W; j++) expW[j] = expQ[j];
    expR = (phase == NSL - 1);
    obsWord = txWord;
    check(txWord == expW, tag, "txWord", txWord, expW);
    check(symReady == expR, "R3", "symReady", symReady, expR);
    symValid = v;
    symData  = d;
    for (int j = 0; j < OUT_W; j++) void'(expQ.pop_front());
    if (expR) begin
      phase = 0;
      if (v) accepts++;
      pushSym(v ? d : IDLE);
    end else begin
      phase++;
    end
  endtask

  task automatic step(logic v, logic [SYM_W-1:0] d);
    @(negedge clk);
    stepBody(v, d);
  endtask

  task automatic doReset();
    logic [OUT_W-1:0] idle0;
    @(negedge clk);
    rst = 1'b1;
    symValid = 1'b0;
    repeat (3) @(negedge clk);
    for (int j = 0; j < OUT_W; j++) idle0[j] = IDLE[j / REP];
    check(txWord == idle0, "R7", "reset txWord", txWord, idle0);
    check(symReady == 1'b0, "R7", "reset symReady", symReady, 0);
    expQ.delete();
    pushSym(IDLE);
    phase = 0;
    rst = 1'b0;
    tag = "R7";
    stepBody(1'b0, '0);
  endtask

  task automatic waitBoundary();
    while (phase != NSL - 1) step(1'b0, '0);
  endtask

  initial begin
    doReset();

    // R5: nothing offered, idle frames only
    tag = "R5";
    repeat (12) step(1'b0, $urandom);

    // R1/R2/R4: single symbol with low bits 1,0,1
    tag = "R2";
    waitBoundary();
    step(1'b1, 10'b0000000101);
    step(1'b0, '0);
    check(obsWord == 20'h003FF, "R1", "first word of 101 symbol", obsWord, 20'h003FF);
    tag = "R4";
    repeat (8) step(1'b0, '0);

    // R6: valid and data toggle while not ready
    tag = "R6";
    repeat (40) step(phase != NSL - 1, $urandom);

    // R8: continuous stream
    tag = "R8";
    accepts = 0;
    repeat (NSL * 8) step(1'b1, $urandom);
    check(accepts == 8, "R8", "accepted symbols", accepts, 8);
    check(dut_i.symReady == 1'b0 || phase == NSL - 1, "R3", "ready alignment", symReady, phase == NSL - 1);

    // R2: random traffic with gaps
    tag = "R2";
    repeat (200) step(($urandom % 3) != 0, $urandom);

    // R7: reset in the middle of a frame
    step(1'b1, $urandom);
    doReset();
    tag = "R5";
    repeat (10) step(1'b0, '0);

    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule